// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Status and Mask Unit

This block gathers the interrupt events of a two-channel IDE host controller and presents them to software through a small byte-wide register port. Each channel has two sources: the level of the drive's interrupt line and a single-cycle pulse that marks the end of a bus-master transfer. The block latches both sources per channel, applies a per-channel mask and drives one host interrupt line per channel. Each line's polarity is set by a per-channel configuration input.

The register port has four byte offsets. Offset 2 has two registers. A read returns the channel-0 status. A write goes to a write-only chip test/mode register, which drives the legacy-compatible and test mode outputs. Offset 3 is readable and holds three things: the two mask bits, the channel-1 status bits, which are read-only, and a strap input that reports whether a legacy header is present.

The bus-master status of a channel stays set until the DMA start register of that channel is written. That write is signalled to this block by a strobe. The drive status follows the raw line, delayed by one register stage.

Top module: `ide_irq_unit`

## Requirements
- R1: After reset both mask bits, both status bits of each channel and both mode outputs are 0, and each host_irq line sits at its deasserted level (host_irq equals pol_low).
- R2: A channel's drive status bit equals the level its drv_irq input had at the previous rising clock edge.
- R3: A one-cycle pulse on bm_done sets that channel's bus-master status bit on the next edge, and the bit holds after the pulse ends.
- R4: A dma_start_wr strobe clears that channel's bus-master status bit on the next edge. When bm_done and dma_start_wr arrive in the same cycle, the bit ends up set.
- R5: A read of offset 2 returns channel-0 drive status in bit 0 and channel-0 bus-master status in bit 1. Bits 7..2 read 0. A write to offset 2 leaves the status unchanged.
- R6: A read of offset 3 returns mask0 in bit 0, mask1 in bit 1, channel-1 drive status in bit 2, channel-1 bus-master status in bit 3 and the legacy_hdr strap in bit 4. Bits 7..5 read 0. A write to offset 3 changes only bits 1..0.
- R7: A write to offset 3 loads bits 1..0 into the mask (1 = masked), and a masked channel's host_irq stays at its deasserted level.
- R8: A channel's host_irq is asserted exactly when at least one of its status bits is 1 and its mask bit is 0. It is asserted high when pol_low is 0 and asserted low when pol_low is 1.
- R9: A write to offset 2 with bit 7 = 1 loads bit 1 into legacy_mode and bit 0 into test_mode. A write to offset 2 with bit 7 = 0 is ignored.
- R10: Offsets 0 and 1 read as 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| drv_irq | input | 2 | Raw drive interrupt level per channel |
| bm_done | input | 2 | Bus-master completion pulse per channel |
| dma_start_wr | input | 2 | DMA start register write strobe per channel |
| pol_low | input | 2 | Per-channel output polarity, 1 = active low |
| legacy_hdr | input | 1 | Strap: legacy header present |
| host_irq | output | 2 | Host interrupt line per channel |
| legacy_mode | output | 1 | Legacy-compatible mode select |
| test_mode | output | 1 | Test mode select |

## Verification
The assertions check four things on every cycle. The drive status must track the raw line one edge later. The bus-master bit must be set after a pulse and cleared after a start strobe. Mask loads and guarded test-register loads must take their write data. The interrupt output must agree with status, mask and polarity. Only the bench scenarios show the read layouts of offsets 2 and 3: the zero-filled upper bits, the strap bit, and the fact that writes to the read-only bits and the unused offsets leave the values read back unchanged. The bench also covers the same-cycle set-versus-clear ordering.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int NUM_CH  = 2;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] OFS_CH0_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_MASK     = 2'd3;

  // Bit positions that software decodes
  localparam int TST_GUARD_BIT  = 7;
  localparam int TST_LEGACY_BIT = 1;
  localparam int TST_TEST_BIT   = 0;
  localparam int MSK_HDR_BIT    = 4;
  localparam int MSK_BM1_BIT    = 3;
  localparam int MSK_DRV1_BIT   = 2;
endpackage

// File: rtl/ide_irq_chan.sv
module ide_irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_raw,
  input  logic bm_pulse,
  input  logic bm_clr,
  input  logic mask,
  input  logic pol_low,
  output logic drv_stat,
  output logic bm_stat,
  output logic irq_out
);
  logic drv_d, bm_d;

  always_comb begin
    drv_d = drv_raw;
    bm_d  = bm_stat;
    if (bm_clr)   bm_d = 1'b0;
    if (bm_pulse) bm_d = 1'b1;   // a completion is never lost to a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_stat <= 1'b0;
      bm_stat  <= 1'b0;
    end else begin
      drv_stat <= drv_d;
      bm_stat  <= bm_d;
    end
  end

  logic active;
  always_comb begin
    active  = (drv_stat | bm_stat) & ~mask;
    irq_out = active ^ pol_low;
  end
endmodule

// File: rtl/ide_irq_regs.sv
module ide_irq_regs
  import ide_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic [NUM_CH-1:0]     drv_stat,
  input  logic [NUM_CH-1:0]     bm_stat,
  input  logic                  legacy_hdr,
  output logic [NUM_CH-1:0]     mask_q,
  output logic                  legacy_q,
  output logic                  test_q,
  output logic [DATA_W-1:0]     reg_rdata
);
  logic              mask_en, tst_en;
  logic [NUM_CH-1:0] mask_d;
  logic              legacy_d, test_d;

  always_comb begin
    mask_en  = reg_wr && (reg_addr == OFS_MASK);
    tst_en   = reg_wr && (reg_addr == OFS_CH0_STAT) && reg_wdata[TST_GUARD_BIT];
    mask_d   = reg_wdata[NUM_CH-1:0];
    legacy_d = reg_wdata[TST_LEGACY_BIT];
    test_d   = reg_wdata[TST_TEST_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      legacy_q <= 1'b0;
      test_q   <= 1'b0;
    end else if (tst_en) begin
      legacy_q <= legacy_d;
      test_q   <= test_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CH0_STAT: begin
        reg_rdata[0] = drv_stat[0];
        reg_rdata[1] = bm_stat[0];
      end
      OFS_MASK: begin
        reg_rdata[NUM_CH-1:0]   = mask_q;
        reg_rdata[MSK_DRV1_BIT] = drv_stat[1];
        reg_rdata[MSK_BM1_BIT]  = bm_stat[1];
        reg_rdata[MSK_HDR_BIT]  = legacy_hdr;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ide_irq_unit.sv
module ide_irq_unit
  import ide_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [1:0]        drv_irq,
  input  logic [1:0]        bm_done,
  input  logic [1:0]        dma_start_wr,
  input  logic [1:0]        pol_low,
  input  logic              legacy_hdr,
  output logic [1:0]        host_irq,
  output logic              legacy_mode,
  output logic              test_mode
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [NUM_CH-1:0] drv_stat, bm_stat, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ide_irq_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .drv_raw  (drv_irq[c]),
      .bm_pulse (bm_done[c]),
      .bm_clr   (dma_start_wr[c]),
      .mask     (mask_q[c]),
      .pol_low  (pol_low[c]),
      .drv_stat (drv_stat[c]),
      .bm_stat  (bm_stat[c]),
      .irq_out  (host_irq[c])
    );
  end

  ide_irq_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .drv_stat   (drv_stat),
    .bm_stat    (bm_stat),
    .legacy_hdr (legacy_hdr),
    .mask_q     (mask_q),
    .legacy_q   (legacy_mode),
    .test_q     (test_mode),
    .reg_rdata  (reg_rdata)
  );
endmodule

// File: rtl/ide_irq_chk.sv
module ide_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [1:0] drv_irq,
  input logic [1:0] bm_done,
  input logic [1:0] dma_start_wr,
  input logic [1:0] pol_low,
  input logic [1:0] drv_stat,
  input logic [1:0] bm_stat,
  input logic [1:0] mask,
  input logic [1:0] host_irq,
  input logic       legacy_mode,
  input logic       test_mode
);
  for (genvar c = 0; c < 2; c++) begin : g_c
    p_drv_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> drv_stat[c] == $past(drv_irq[c]));
    p_bm_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bm_done[c] |=> bm_stat[c]);
    p_bm_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_start_wr[c] && !bm_done[c]) |=> !bm_stat[c]);
    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mask[c] |-> host_irq[c] == pol_low[c]);
    p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask[c] && (drv_stat[c] || bm_stat[c])) |-> host_irq[c] != pol_low[c]);
  end

  p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3) |=> mask == $past(reg_wdata[1:0]));
  p_test_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && reg_wdata[7]) |=>
      (legacy_mode == $past(reg_wdata[1]) && test_mode == $past(reg_wdata[0])));
  p_test_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && !reg_wdata[7]) |=>
      ($stable(legacy_mode) && $stable(test_mode)));
endmodule

bind ide_irq_unit ide_irq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .drv_irq      (drv_irq),
  .bm_done      (bm_done),
  .dma_start_wr (dma_start_wr),
  .pol_low      (pol_low),
  .drv_stat     (drv_stat),
  .bm_stat      (bm_stat),
  .mask         (mask_q),
  .host_irq     (host_irq),
  .legacy_mode  (legacy_mode),
  .test_mode    (test_mode)
);

// File: tb/ide_irq_unit_tb.sv
`timescale 1ns/1ps
module ide_irq_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [1:0] drv_irq = 2'b00;
  logic [1:0] bm_done = 2'b00;
  logic [1:0] dma_start_wr = 2'b00;
  logic [1:0] pol_low = 2'b00;
  logic       legacy_hdr = 1'b0;
  logic [1:0] host_irq;
  logic       legacy_mode, test_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ide_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drv_irq(drv_irq),
    .bm_done(bm_done), .dma_start_wr(dma_start_wr), .pol_low(pol_low),
    .legacy_hdr(legacy_hdr), .host_irq(host_irq),
    .legacy_mode(legacy_mode), .test_mode(test_mode)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd2, v); chk("R1 stat0", v, 8'h00);
    rd(2'd3, v); chk("R1 mask reg", v, 8'h00);
    chk("R1 modes", {6'd0, legacy_mode, test_mode}, 8'h00);
    chk("R1 host_irq", {6'd0, host_irq}, {6'd0, pol_low});
  endtask

  task automatic t_drive_level;
    logic [7:0] v;
    @(negedge clk); drv_irq = 2'b01;
    rd(2'd2, v); chk("R2 before edge", v, 8'h00);
    @(negedge clk);
    rd(2'd2, v); chk("R2 drv0 set / R5 layout", v, 8'h01);
    chk("R8 ch0 high", {7'd0, host_irq[0]}, 8'h01);
    drv_irq = 2'b10;
    @(negedge clk);
    rd(2'd2, v); chk("R2 drv0 cleared", v, 8'h00);
    rd(2'd3, v); chk("R2 drv1 in R6 bit2", v, 8'h04);
    drv_irq = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_bm;
    logic [7:0] v;
    @(negedge clk); bm_done = 2'b01;
    @(negedge clk); bm_done = 2'b00;
    rd(2'd2, v); chk("R3 bm0 set, R5 bit1", v, 8'h02);
    @(negedge clk); @(negedge clk);
    rd(2'd2, v); chk("R3 bm0 holds", v, 8'h02);
    chk("R8 bm asserts ch0", {7'd0, host_irq[0]}, 8'h01);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R5 write leaves status", v, 8'h02);
    dma_start_wr = 2'b01;
    @(negedge clk); dma_start_wr = 2'b00;
    rd(2'd2, v); chk("R4 bm0 cleared", v, 8'h00);
    bm_done = 2'b10; dma_start_wr = 2'b10;
    @(negedge clk); bm_done = 2'b00; dma_start_wr = 2'b00;
    rd(2'd3, v); chk("R4 same-cycle set wins, R6 bit3", v, 8'h08);
    dma_start_wr = 2'b10;
    @(negedge clk); dma_start_wr = 2'b00;
    rd(2'd3, v); chk("R4 bm1 cleared", v, 8'h00);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    drv_irq = 2'b11;
    @(negedge clk);
    chk("R8 both asserted", {6'd0, host_irq}, 8'h03);
    wr(2'd3, 8'h01);
    chk("R7 ch0 masked", {6'd0, host_irq}, 8'h02);
    rd(2'd3, v); chk("R7 mask readback", v, 8'h05);
    wr(2'd3, 8'h02);
    chk("R7 ch1 masked", {6'd0, host_irq}, 8'h01);
    wr(2'd3, 8'h00);
    drv_irq = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_polarity;
    @(negedge clk); pol_low = 2'b10;
    #0.5 chk("R8 idle low-active ch1 high", {6'd0, host_irq}, 8'h02);
    drv_irq = 2'b10;
    @(negedge clk);
    chk("R8 active-low asserted", {6'd0, host_irq}, 8'h00);
    wr(2'd3, 8'h02);
    chk("R7 masked low-active idles high", {6'd0, host_irq}, 8'h02);
    wr(2'd3, 8'h00);
    drv_irq = 2'b00; pol_low = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_test_reg;
    wr(2'd2, 8'h83);
    chk("R9 load 1/1", {6'd0, legacy_mode, test_mode}, 8'h03);
    wr(2'd2, 8'h00);
    chk("R9 guard bit clear ignored", {6'd0, legacy_mode, test_mode}, 8'h03);
    wr(2'd2, 8'h82);
    chk("R9 load legacy only", {6'd0, legacy_mode, test_mode}, 8'h02);
    wr(2'd2, 8'h80);
    chk("R9 load 0/0", {6'd0, legacy_mode, test_mode}, 8'h00);
  endtask

  task automatic t_ro_bits;
    logic [7:0] v;
    wr(2'd3, 8'hFC);
    rd(2'd3, v); chk("R6 read-only bits ignore write", v, 8'h00);
    legacy_hdr = 1'b1;
    rd(2'd3, v); chk("R6 strap bit4", v, 8'h10);
    legacy_hdr = 1'b0;
  endtask

  task automatic t_unused;
    logic [7:0] v;
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    rd(2'd0, v); chk("R10 offset0 zero", v, 8'h00);
    rd(2'd1, v); chk("R10 offset1 zero", v, 8'h00);
    rd(2'd3, v); chk("R10 mask untouched", v, 8'h00);
    chk("R10 modes untouched", {6'd0, legacy_mode, test_mode}, 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_drive_level();
    t_bm();
    t_mask();
    t_polarity();
    t_test_reg();
    t_ro_bits();
    t_unused();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule